// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns a parallel word into an asynchronous serial frame on a single output line. It is driven by a tick that runs at sixteen times the bit rate. The shape of each frame is set at run time. The word can take 7, 8 or 9 bit slots. Parity can be on or off, and odd or even. The stop period can be one half, one, one and a half or two bit times. When parity is on, the parity bit sits in the last slot of the word, so one data bit fewer is carried.

Words arrive through a valid/ready handshake. Two further strobes ask for special frames. A break frame holds the line low for longer than any legal character. An idle frame keeps the line high for one whole frame time. A busy flag is high while a frame is on the line. A one-cycle pulse marks the end of each frame. The configuration is captured when a frame begins, so software or a neighbouring block may change it at any time.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line `txd` is high, `busy` is low and `in_ready` is high. Whenever `busy` is low, `txd` is high.
- R2: `cfg_len` sets the number of word slots: 00 gives 8, 01 gives 9, 10 gives 7, and 11 is treated as 8. A data frame is one low start bit, then the word slots sent LSB first from `in_data`, then the stop period.
- R3: With `cfg_par_en`=1 the last word slot carries parity, and only the lower (slots-1) bits of `in_data` are sent. The parity is computed over the sent bits only. `cfg_par_odd`=1 makes the count of ones in data plus parity odd; 0 makes it even.
- R4: `cfg_stop` sets a stop period with `txd` high for 16 ticks (00), 8 ticks (01), 32 ticks (10) or 24 ticks (11).
- R5: Each start, data, parity or break bit lasts exactly 16 `tick` pulses. `txd` changes level during a frame only on a cycle with a tick.
- R6: A break frame (`brk_req`) holds `txd` low for (slots+2) bit times, which is 10 for 8 slots, 9 for 7 and 11 for 9. The programmed stop period follows.
- R7: An idle frame (`idle_req`) holds `txd` high for (slots+1) bit times, start slot included. The programmed stop period follows.
- R8: The length, stop and parity settings are taken at the start of a frame. Changing them while the frame is running has no effect on that frame.
- R9: `in_ready` is high only while no frame is running and no request is pending. A word is taken on a cycle with `in_valid` and `in_ready` both high. The transmitter stores break and idle strobes and serves them after the current frame ends. A break is served before an idle, and an idle before a new word.
- R10: `done` pulses high for exactly one cycle at the end of every frame. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| in_data | input | 9 | Word to send |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word can be taken |
| cfg_len | input | 2 | Word slot count select |
| cfg_stop | input | 2 | Stop period select |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| brk_req | input | 1 | Break frame request strobe |
| idle_req | input | 1 | Idle frame request strobe |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situations to reach are the queued ones. One is a break strobe that lands in the middle of a data frame. Another is a break and an idle strobe that arrive in the same cycle. In both cases the order and the gap between frames only show up after a full frame has passed. The bench records the line at every tick across back-to-back frames until the expected number of end pulses is seen. It then compares the whole record with a concatenated model of the frames. The settings are also changed right after a word is accepted, to show that the running frame keeps the values it captured at its start.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    cfg_len,
  input  logic [1:0]    cfg_stop,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          brk_req,
  input  logic          idle_req,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int SW = DW + 2;
  localparam int CW = $clog2(2 * OVS + 1);
  localparam int LW = $clog2(SW + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_BITS, PH_STOP} phase_t;

  phase_t        ph;
  logic [SW-1:0] sh;
  logic [LW-1:0] left;
  logic [CW-1:0] cnt, stop_t;
  logic          brk_p, idl_p;

  logic [LW-1:0] wlen, dlen;
  logic [DW-1:0] dsel, word;
  logic [CW-1:0] stop_ticks;
  logic          par, accept, go_brk, go_idl, go_any;

  always_comb begin
    case (cfg_len)
      2'b01:   wlen = LW'(DW);
      2'b10:   wlen = LW'(DW - 2);
      default: wlen = LW'(DW - 1);
    endcase
    case (cfg_stop)
      2'b01:   stop_ticks = CW'(OVS / 2);
      2'b10:   stop_ticks = CW'(2 * OVS);
      2'b11:   stop_ticks = CW'(OVS + OVS / 2);
      default: stop_ticks = CW'(OVS);
    endcase
  end

  assign dlen = wlen - LW'(cfg_par_en);
  assign dsel = in_data & ~({DW{1'b1}} << dlen);
  assign par  = (^dsel) ^ cfg_par_odd;
  assign word = cfg_par_en ? (dsel | (DW'(par) << (wlen - LW'(1)))) : dsel;

  assign busy     = (ph != PH_IDLE);
  assign in_ready = !busy && !brk_p && !idl_p;
  assign accept   = in_valid && in_ready;
  assign go_brk   = !busy && brk_p;
  assign go_idl   = !busy && !brk_p && idl_p;
  assign go_any   = accept || go_brk || go_idl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      sh     <= '0;
      left   <= '0;
      cnt    <= '0;
      stop_t <= '0;
      txd    <= 1'b1;
      done   <= 1'b0;
      brk_p  <= 1'b0;
      idl_p  <= 1'b0;
    end else begin
      done  <= 1'b0;
      brk_p <= (brk_p && !go_brk) || brk_req;
      idl_p <= (idl_p && !go_idl) || idle_req;
      if (go_any) begin
        ph     <= PH_BITS;
        cnt    <= '0;
        stop_t <= stop_ticks;
        if (go_brk) begin
          sh   <= '0;
          left <= wlen + LW'(2);
          txd  <= 1'b0;
        end else if (go_idl) begin
          sh   <= '1;
          left <= wlen + LW'(1);
          txd  <= 1'b1;
        end else begin
          sh   <= {1'b0, word, 1'b0};
          left <= wlen + LW'(1);
          txd  <= 1'b0;
        end
      end else if (tick) begin
        case (ph)
          PH_BITS: begin
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              if (left == LW'(1)) begin
                ph  <= PH_STOP;
                txd <= 1'b1;
              end else begin
                sh   <= sh >> 1;
                txd  <= sh[1];
                left <= left - LW'(1);
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          PH_STOP: begin
            if (cnt == stop_t - CW'(1)) begin
              cnt  <= '0;
              ph   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy,
  input logic done
);
  a_r1_line_high_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r9_ready_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);

  a_r9_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(txd) && $past(busy) && busy) |-> $past(tick));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .busy(busy), .done(done)
);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
  logic       clk = 0, rst_n = 0, tick = 0;
  logic [8:0] in_data = '0;
  logic       in_valid = 0, in_ready;
  logic [1:0] cfg_len = 0, cfg_stop = 0;
  logic       cfg_par_en = 0, cfg_par_odd = 0;
  logic       brk_req = 0, idle_req = 0;
  logic       txd, busy, done;

  int checks = 0, fails = 0;
  logic rec [0:2047];
  logic expv [0:2047];
  int nrec = 0, nexp = 0, ndone = 0;

  always #10 clk = ~clk;

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_len(cfg_len),
    .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .brk_req(brk_req), .idle_req(idle_req), .txd(txd), .busy(busy), .done(done)
  );

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  end

  always @(negedge clk) begin
    #1;
    if (tick && busy && nrec < 2048) begin
      rec[nrec] = txd;
      nrec++;
    end
    if (done) ndone++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  function automatic int slots(input logic [1:0] l);
    return (l == 2'b01) ? 9 : (l == 2'b10) ? 7 : 8;
  endfunction

  function automatic int stop_len(input logic [1:0] s);
    return (s == 2'b01) ? 8 : (s == 2'b10) ? 32 : (s == 2'b11) ? 24 : 16;
  endfunction

  task automatic push(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      expv[nexp] = v;
      nexp++;
    end
  endtask

  // kind: 0 data, 1 break, 2 idle
  task automatic build(input int kind, input logic [1:0] l, input logic [1:0] s,
                       input logic pe, input logic po, input logic [8:0] d);
    int L;
    logic p;
    L = slots(l);
    if (kind == 1) push(1'b0, (L + 2) * 16);
    else if (kind == 2) push(1'b1, (L + 1) * 16);
    else begin
      push(1'b0, 16);
      p = po;
      for (int i = 0; i < L - 1; i++) if (pe) p = p ^ d[i];
      for (int i = 0; i < L; i++)
        push((pe && i == L - 1) ? p : d[i], 16);
    end
    push(1'b1, stop_len(s));
  endtask

  task automatic start_rec();
    @(negedge clk);
    nrec = 0; nexp = 0; ndone = 0;
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [1:0] s, input logic pe, input logic po);
    cfg_len = l; cfg_stop = s; cfg_par_en = pe; cfg_par_odd = po;
  endtask

  task automatic send(input logic [8:0] d);
    @(negedge clk);
    in_data = d; in_valid = 1;
    @(negedge clk);
    while (!busy) @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_frames(input int n);
    while (ndone < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req, input int nd);
    int bad;
    bad = -1;
    chk(nrec == nexp, {req, " frame length in ticks"}, nrec, nexp);
    for (int i = 0; i < nexp && i < nrec; i++)
      if (bad < 0 && rec[i] !== expv[i]) bad = i;
    if (bad >= 0) chk(0, {req, " line level at tick"}, bad, -1);
    else chk(1, req, 0, 0);
    chk(ndone == nd, {req, " R10 done pulse count"}, ndone, nd);
  endtask

  task automatic t_data(input string req, input logic [1:0] l, input logic [1:0] s,
                        input logic pe, input logic po, input logic [8:0] d);
    set_cfg(l, s, pe, po);
    start_rec();
    build(0, l, s, pe, po, d);
    send(d);
    wait_frames(1);
    compare(req, 1);
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(done === 1'b0, "R10 done after reset", done, 0);
  endtask

  task automatic t_special(input string req, input int kind, input logic [1:0] l, input logic [1:0] s);
    set_cfg(l, s, 0, 0);
    start_rec();
    build(kind, l, s, 0, 0, 9'h0);
    @(negedge clk);
    if (kind == 1) brk_req = 1; else idle_req = 1;
    @(negedge clk);
    brk_req = 0; idle_req = 0;
    wait_frames(1);
    compare(req, 1);
  endtask

  task automatic t_cfg_hold();
    set_cfg(2'b00, 2'b00, 1, 0);
    start_rec();
    build(0, 2'b00, 2'b00, 1, 0, 9'h06B);
    send(9'h06B);
    set_cfg(2'b01, 2'b10, 0, 1);
    wait_frames(1);
    compare("R8 settings held during frame", 1);
  endtask

  task automatic t_queue();
    set_cfg(2'b00, 2'b00, 0, 0);
    start_rec();
    build(0, 2'b00, 2'b00, 0, 0, 9'h0F0);
    build(1, 2'b00, 2'b00, 0, 0, 9'h0);
    send(9'h0F0);
    repeat (40) @(negedge clk);
    chk(in_ready === 1'b0, "R9 in_ready low while busy", in_ready, 0);
    brk_req = 1;
    @(negedge clk);
    brk_req = 0;
    wait_frames(2);
    compare("R9 break waits for data frame", 2);
  endtask

  task automatic t_priority();
    set_cfg(2'b10, 2'b01, 0, 0);
    start_rec();
    build(1, 2'b10, 2'b01, 0, 0, 9'h0);
    build(2, 2'b10, 2'b01, 0, 0, 9'h0);
    @(negedge clk);
    brk_req = 1; idle_req = 1;
    @(negedge clk);
    brk_req = 0; idle_req = 0;
    chk(in_ready === 1'b0, "R9 in_ready low with pending request", in_ready, 0);
    wait_frames(2);
    compare("R9 break before idle", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data("R2 R5 8 slots 1 stop", 2'b00, 2'b00, 0, 0, 9'h0A5);
    t_data("R2 9 slots no parity", 2'b01, 2'b00, 0, 0, 9'h155);
    t_data("R2 7 slots no parity", 2'b10, 2'b00, 0, 0, 9'h1FF);
    t_data("R3 7 slots even parity", 2'b10, 2'b00, 1, 0, 9'h05B);
    t_data("R3 9 slots odd parity", 2'b01, 2'b00, 1, 1, 9'h1C3);
    t_data("R3 8 slots odd parity", 2'b00, 2'b00, 1, 1, 9'h0FF);
    t_data("R4 half stop", 2'b00, 2'b01, 0, 0, 9'h03C);
    t_data("R4 two stop", 2'b00, 2'b10, 0, 0, 9'h081);
    t_data("R4 one and a half stop", 2'b00, 2'b11, 1, 0, 9'h012);
    t_special("R6 break 8 slots", 1, 2'b00, 2'b00);
    t_special("R6 break 7 slots", 1, 2'b10, 2'b00);
    t_special("R6 break 9 slots", 1, 2'b01, 2'b11);
    t_special("R7 idle 8 slots", 2, 2'b00, 2'b00);
    t_cfg_hold();
    t_queue();
    t_priority();
    chk(txd === 1'b1 && busy === 1'b0, "R1 line high at end", txd, 1);
    summary();
  end
endmodule